// File: doc/BRIEF.md
# FIFO Programmable-Flag Offset Loader

This block holds the two threshold offsets that a FIFO's almost-empty and almost-full flag logic compares against occupancy. The offsets can be loaded in one of two ways, chosen by a static mode input. In serial mode a one-bit input is shifted in on a dedicated serial clock. In parallel mode the offsets arrive as four enabled writes on the FIFO's own write data bus, qualified by the load strobe.

In both modes the new offsets take effect together, and only when the whole image has arrived. A serial sequence can be paused at any bit and resumed later. Ordinary FIFO writes may be interleaved during a pause without disturbing the load. While a load is partly done, both flag-valid outputs go low. Once the load completes, each valid output rises again after a fixed three-edge synchronisation delay in its own clock domain: the write clock for almost-full and the read clock for almost-empty.

Top module: `flag_offset_loader`

## Requirements
- R1: A synchronous reset, active high, clears the serial bit position and the parallel word position. It loads the default offsets (empty = 0x0007F, full = 0x000FF) and drives both flag-valid outputs high.
- R2: In serial mode (`par_mode`=0), one bit of `ser_din` is taken on each rising `sclk` edge where `load_n`=0 and `ser_en_n`=0. Bit k of the sequence (k = 0..37) goes to empty-offset bit k for k < 19, and to full-offset bit k-19 otherwise.
- R3: In serial mode the offset outputs change only on the edge that takes the 38th bit, and both offsets change together on that edge. The whole sequence can be loaded again any number of times.
- R4: With `load_n`=0 and `ser_en_n`=1, no bit is taken and the serial position is kept.
- R5: Raising `load_n` or `ser_en_n` pauses the serial sequence. Ordinary writes made during the pause (`load_n`=1, `wr_en_n`=0) leave the offsets unchanged. When both inputs are low again, shifting resumes at the next bit in order.
- R6: After the edge that completes a load, `afull_valid` goes high on the third following `wclk` edge and `aempty_valid` on the third following `rclk` edge.
- R7: Once the first bit or word of a load has been taken, both valid outputs go low three edges later in their own domains. They stay low until the load completes, with the timing given in R6.
- R8: In parallel mode (`par_mode`=1), a word is taken on each rising `wclk` edge where `load_n`=0 and `wr_en_n`=0. Words 1 and 2 form the empty offset; words 3 and 4 form the full offset.
- R9: In each parallel pair, the first word supplies offset bits [9:0] from `wr_data[9:0]` and the second supplies bits [18:10] from `wr_data[8:0]`. Both offsets update together on the fourth word. The next word then starts again at the empty offset.
- R10: In parallel mode, writes with `load_n`=1 have no effect on the offsets. In parallel mode the serial inputs are ignored. In serial mode, `wr_data` writes are ignored even when `load_n`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial loading clock |
| wclk | input | 1 | FIFO write clock |
| rclk | input | 1 | FIFO read clock |
| rst | input | 1 | Synchronous reset, active high |
| par_mode | input | 1 | Static mode select: 1 = parallel loading, 0 = serial |
| load_n | input | 1 | Offset load strobe, active low |
| ser_en_n | input | 1 | Serial shift enable, active low |
| ser_din | input | 1 | Serial offset data |
| wr_en_n | input | 1 | FIFO write enable, active low |
| wr_data | input | DATA_W | FIFO write data bus |
| empty_ofs | output | 19 | Almost-empty offset |
| full_ofs | output | 19 | Almost-full offset |
| afull_valid | output | 1 | Almost-full flag is valid (write-clock domain) |
| aempty_valid | output | 1 | Almost-empty flag is valid (read-clock domain) |

## Verification
The bench goes after a serial load that is stopped mid-sequence in both ways: with the shift enable high, and with the load strobe high while ordinary writes go through. A design that lost or repeated a bit across a pause would commit a rotated image instead of the pattern sent. Images with set bits at the very first and last positions expose a swapped half or a reversed bit order. Checks in the middle of a load expose a design that updates one offset early or keeps the flags valid.

In parallel mode, a second four-word load tests the wrap back to the empty offset. Writes without the load strobe, and serial activity, must leave the offsets untouched. The valid outputs are checked on the exact third edge, which catches a short or long synchroniser.

// File: rtl/flo_pkg.sv
package flo_pkg;
    localparam int OFS_W     = 19;
    localparam int LO_W      = (OFS_W + 1) / 2;
    localparam int HI_W      = OFS_W - LO_W;
    localparam int SER_BITS  = 2 * OFS_W;
    localparam int SER_CNT_W = $clog2(SER_BITS);

    typedef logic [OFS_W-1:0] ofs_t;

    // full in the upper half so a serial image maps straight onto the struct
    typedef struct packed {
        ofs_t full;
        ofs_t empty;
    } ofs_pair_t;

    typedef enum logic [1:0] {
        W_EMPTY_LO = 2'd0,
        W_EMPTY_HI = 2'd1,
        W_FULL_LO  = 2'd2,
        W_FULL_HI  = 2'd3
    } word_e;

    function automatic ofs_pair_t join_words(
        input logic [LO_W-1:0] e_lo, input logic [HI_W-1:0] e_hi,
        input logic [LO_W-1:0] f_lo, input logic [HI_W-1:0] f_hi);
        ofs_pair_t p;
        p.empty = {e_hi, e_lo};
        p.full  = {f_hi, f_lo};
        return p;
    endfunction
endpackage

// File: rtl/flo_serial_shift.sv
module flo_serial_shift
    import flo_pkg::*;
#(
    parameter ofs_pair_t DEF = '0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 load_n,
    input  logic                 ser_en_n,
    input  logic                 din,
    output ofs_pair_t            image,
    output logic                 busy,
    output logic [SER_CNT_W-1:0] bitpos
);
    localparam logic [SER_CNT_W-1:0] LAST = SER_CNT_W'(SER_BITS - 1);

    logic [SER_BITS-2:0] stage;
    logic                take;

    assign take = en && !load_n && !ser_en_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            bitpos <= '0;
            stage  <= '0;
            image  <= DEF;
        end else if (take) begin
            if (bitpos == LAST) begin
                image  <= ofs_pair_t'({din, stage});
                bitpos <= '0;
            end else begin
                stage[bitpos] <= din;
                bitpos        <= bitpos + 1'b1;
            end
        end
    end

    assign busy = (bitpos != '0);
endmodule

// File: rtl/flo_parallel_load.sv
module flo_parallel_load
    import flo_pkg::*;
#(
    parameter int        DATA_W = 36,
    parameter ofs_pair_t DEF    = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              load_n,
    input  logic              wr_en_n,
    input  logic [DATA_W-1:0] wr_data,
    output ofs_pair_t         image,
    output logic              busy,
    output word_e             wordpos
);
    logic [LO_W-1:0] e_lo, f_lo;
    logic [HI_W-1:0] e_hi;
    logic            take;
    logic            unused_upper;

    assign take         = en && !load_n && !wr_en_n;
    assign unused_upper = ^wr_data[DATA_W-1:LO_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            wordpos <= W_EMPTY_LO;
            e_lo    <= '0;
            e_hi    <= '0;
            f_lo    <= '0;
            image   <= DEF;
        end else if (take) begin
            unique case (wordpos)
                W_EMPTY_LO: e_lo <= wr_data[LO_W-1:0];
                W_EMPTY_HI: e_hi <= wr_data[HI_W-1:0];
                W_FULL_LO:  f_lo <= wr_data[LO_W-1:0];
                W_FULL_HI:  image <= join_words(e_lo, e_hi, f_lo, wr_data[HI_W-1:0]);
                default:    ;
            endcase
            wordpos <= wordpos.next();
        end
    end

    assign busy = (wordpos != W_EMPTY_LO);
endmodule

// File: rtl/flo_sync.sv
module flo_sync #(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= 1'b1;
                else     chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/flag_offset_loader.sv
module flag_offset_loader
    import flo_pkg::*;
#(
    parameter int   DATA_W      = 36,
    parameter int   SYNC_STAGES = 3,
    parameter ofs_t DEF_EMPTY   = 19'h0007F,
    parameter ofs_t DEF_FULL    = 19'h000FF
) (
    input  logic              sclk,
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst,
    input  logic              par_mode,
    input  logic              load_n,
    input  logic              ser_en_n,
    input  logic              ser_din,
    input  logic              wr_en_n,
    input  logic [DATA_W-1:0] wr_data,
    output logic [OFS_W-1:0]  empty_ofs,
    output logic [OFS_W-1:0]  full_ofs,
    output logic              afull_valid,
    output logic              aempty_valid
);
    localparam ofs_pair_t DEF = '{full: DEF_FULL, empty: DEF_EMPTY};

    ofs_pair_t            ser_img, par_img, sel_img;
    logic                 ser_busy, par_busy, img_busy;
    logic [SER_CNT_W-1:0] ser_bitpos;
    word_e                par_wordpos;

    flo_serial_shift #(.DEF(DEF)) u_ser (
        .clk(sclk), .rst(rst), .en(!par_mode), .load_n(load_n),
        .ser_en_n(ser_en_n), .din(ser_din), .image(ser_img),
        .busy(ser_busy), .bitpos(ser_bitpos)
    );

    flo_parallel_load #(.DATA_W(DATA_W), .DEF(DEF)) u_par (
        .clk(wclk), .rst(rst), .en(par_mode), .load_n(load_n),
        .wr_en_n(wr_en_n), .wr_data(wr_data), .image(par_img),
        .busy(par_busy), .wordpos(par_wordpos)
    );

    assign sel_img   = par_mode ? par_img : ser_img;
    assign img_busy  = par_mode ? par_busy : ser_busy;
    assign empty_ofs = sel_img.empty;
    assign full_ofs  = sel_img.full;

    flo_sync #(.STAGES(SYNC_STAGES)) u_sync_wr (
        .clk(wclk), .rst(rst), .d(!img_busy), .q(afull_valid)
    );

    flo_sync #(.STAGES(SYNC_STAGES)) u_sync_rd (
        .clk(rclk), .rst(rst), .d(!img_busy), .q(aempty_valid)
    );
endmodule

// File: rtl/flo_checker.sv
module flo_checker
    import flo_pkg::*;
(
    input logic                 sclk,
    input logic                 wclk,
    input logic                 rst,
    input logic                 par_mode,
    input logic                 load_n,
    input logic                 ser_en_n,
    input logic                 wr_en_n,
    input logic [SER_CNT_W-1:0] ser_bitpos,
    input word_e                par_wordpos,
    input logic [OFS_W-1:0]     empty_ofs,
    input logic [OFS_W-1:0]     full_ofs,
    input logic                 afull_valid,
    input logic                 aempty_valid
);
    localparam logic [SER_CNT_W-1:0] LAST = SER_CNT_W'(SER_BITS - 1);

    a_r4_pause_keeps_position: assert property (@(posedge sclk) disable iff (rst)
        (par_mode || load_n || ser_en_n) |=> $stable(ser_bitpos));

    a_r3_no_partial_update: assert property (@(posedge sclk) disable iff (rst)
        (!par_mode && !(!load_n && !ser_en_n && ser_bitpos == LAST))
        |=> ($stable(empty_ofs) && $stable(full_ofs)));

    a_r9_word_wrap: assert property (@(posedge wclk) disable iff (rst)
        (par_mode && !load_n && !wr_en_n && par_wordpos == W_FULL_HI)
        |=> (par_wordpos == W_EMPTY_LO));

    a_r10_no_load_no_change: assert property (@(posedge wclk) disable iff (rst)
        (par_mode && load_n) |=> ($stable(empty_ofs) && $stable(full_ofs)));

    a_r2_position_in_range: assert property (@(posedge sclk) disable iff (rst)
        ser_bitpos <= LAST);

    a_r1_valid_after_reset: assert property (@(posedge wclk)
        $fell(rst) |-> (afull_valid && aempty_valid));
endmodule

bind flag_offset_loader flo_checker u_chk (
    .sclk(sclk), .wclk(wclk), .rst(rst), .par_mode(par_mode),
    .load_n(load_n), .ser_en_n(ser_en_n), .wr_en_n(wr_en_n),
    .ser_bitpos(ser_bitpos), .par_wordpos(par_wordpos),
    .empty_ofs(empty_ofs), .full_ofs(full_ofs),
    .afull_valid(afull_valid), .aempty_valid(aempty_valid)
);

// File: tb/flag_offset_loader_bench.sv
module flag_offset_loader_bench;
    localparam int DATA_W = 36;
    localparam logic [18:0] DEF_E = 19'h0007F;
    localparam logic [18:0] DEF_F = 19'h000FF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic par_mode = 1'b0;
    logic load_n = 1'b1, ser_en_n = 1'b1, ser_din = 1'b0, wr_en_n = 1'b1;
    logic [DATA_W-1:0] wr_data = '0;
    logic [18:0] empty_ofs, full_ofs;
    logic afull_valid, aempty_valid;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    flag_offset_loader #(.DATA_W(DATA_W)) u_flag_offset_loader (
        .sclk(clk), .wclk(clk), .rclk(clk), .rst(rst), .par_mode(par_mode),
        .load_n(load_n), .ser_en_n(ser_en_n), .ser_din(ser_din),
        .wr_en_n(wr_en_n), .wr_data(wr_data), .empty_ofs(empty_ofs),
        .full_ofs(full_ofs), .afull_valid(afull_valid), .aempty_valid(aempty_valid)
    );

    // behavioural reference model
    int          m_scnt, m_wcnt;
    logic [37:0] m_sbits;
    logic [18:0] m_se, m_sf, m_pe, m_pf;
    logic [DATA_W-1:0] m_w0, m_w1, m_w2;
    bit          vq[$];
    bit          m_live = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_scnt = 0; m_wcnt = 0; m_sbits = '0;
            m_se = DEF_E; m_sf = DEF_F; m_pe = DEF_E; m_pf = DEF_F;
            vq = '{1, 1, 1};
            m_live = 1;
        end else begin
            bit busy;
            busy = par_mode ? (m_wcnt != 0) : (m_scnt != 0);
            vq.push_back(!busy);
            vq.delete(0);
            if (!par_mode && !load_n && !ser_en_n) begin
                m_sbits[m_scnt] = ser_din;
                if (m_scnt == 37) begin
                    m_se = m_sbits[18:0];
                    m_sf = m_sbits[37:19];
                    m_scnt = 0;
                end else m_scnt++;
            end
            if (par_mode && !load_n && !wr_en_n) begin
                case (m_wcnt)
                    0: m_w0 = wr_data;
                    1: m_w1 = wr_data;
                    2: m_w2 = wr_data;
                    default: begin
                        m_pe = {m_w1[8:0], m_w0[9:0]};
                        m_pf = {wr_data[8:0], m_w2[9:0]};
                    end
                endcase
                m_wcnt = (m_wcnt + 1) % 4;
            end
        end
    end

    always @(negedge clk) begin
        if (m_live && !rst) begin
            logic [18:0] xe, xf;
            xe = par_mode ? m_pe : m_se;
            xf = par_mode ? m_pf : m_sf;
            checks++;
            if (empty_ofs !== xe || full_ofs !== xf) begin
                errors++;
                $display("FAIL R3/R9 model offsets: got %h/%h expected %h/%h",
                         empty_ofs, full_ofs, xe, xf);
            end
            checks++;
            if (afull_valid !== vq[0] || aempty_valid !== vq[0]) begin
                errors++;
                $display("FAIL R6/R7 model valid: got %b/%b expected %b",
                         afull_valid, aempty_valid, vq[0]);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [37:0] got,
                       input logic [37:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic ser_range(input logic [37:0] img, input int lo, input int hi,
                             input int pause_every);
        for (int i = lo; i <= hi; i++) begin
            load_n = 0; ser_en_n = 0; ser_din = img[i];
            @(negedge clk);
            if (pause_every != 0 && (i % pause_every) == 0 && i != 37) begin
                ser_en_n = 1; ser_din = ~ser_din;          // R4 style pause
                repeat (2) @(negedge clk);
                load_n = 1; wr_en_n = 0; wr_data = {DATA_W{1'b1}} ^ DATA_W'(i); // R5 writes
                repeat (2) @(negedge clk);
                wr_en_n = 1;
            end
        end
        load_n = 1; ser_en_n = 1;
    endtask

    task automatic par_word(input logic [DATA_W-1:0] d);
        load_n = 0; wr_en_n = 0; wr_data = d;
        @(negedge clk);
        load_n = 1; wr_en_n = 1;
    endtask

    task automatic do_reset(input bit mode);
        rst = 1; par_mode = mode;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        logic [37:0] img_a, img_b;
        logic [DATA_W-1:0] w0, w1, w2, w3;
        img_a = {19'h05E7B, 19'h1A5C3};
        img_b = {19'h40001, 19'h3FFFE};

        do_reset(0);
        chk(empty_ofs == DEF_E && full_ofs == DEF_F, "R1 default offsets",
            {full_ofs, empty_ofs}, {DEF_F, DEF_E});
        chk(afull_valid && aempty_valid, "R1 valid after reset",
            {afull_valid, aempty_valid}, 2'b11);

        // R2 continuous serial load
        ser_range(img_a, 0, 37, 0);
        chk({full_ofs, empty_ofs} == img_a, "R2 serial image",
            {full_ofs, empty_ofs}, img_a);
        repeat (2) @(negedge clk);
        chk(!afull_valid && !aempty_valid, "R6 still invalid at edge two",
            {afull_valid, aempty_valid}, 2'b00);
        @(negedge clk);
        chk(afull_valid && aempty_valid, "R6 valid at edge three",
            {afull_valid, aempty_valid}, 2'b11);

        // R7/R3 partial sequence
        ser_range(img_b, 0, 4, 0);
        repeat (3) @(negedge clk);
        chk(!afull_valid && !aempty_valid, "R7 invalid mid-load",
            {afull_valid, aempty_valid}, 2'b00);
        chk({full_ofs, empty_ofs} == img_a, "R3 no partial update",
            {full_ofs, empty_ofs}, img_a);
        load_n = 0; ser_en_n = 1; ser_din = 1;
        repeat (4) @(negedge clk);
        chk({full_ofs, empty_ofs} == img_a, "R4 no shift with enable high",
            {full_ofs, empty_ofs}, img_a);
        load_n = 1;
        ser_range(img_b, 5, 37, 3);
        chk({full_ofs, empty_ofs} == img_b, "R5 resumed image",
            {full_ofs, empty_ofs}, img_b);
        repeat (3) @(negedge clk);
        chk(afull_valid && aempty_valid, "R6 valid after resumed load",
            {afull_valid, aempty_valid}, 2'b11);

        // R10 serial mode ignores parallel writes
        for (int k = 0; k < 4; k++) par_word(DATA_W'(36'h123456789) << k);
        repeat (3) @(negedge clk);
        chk({full_ofs, empty_ofs} == img_b && afull_valid, "R10 serial ignores bus",
            {full_ofs, empty_ofs}, img_b);
        ser_range(img_a, 0, 37, 0);
        chk({full_ofs, empty_ofs} == img_a, "R3 reload",
            {full_ofs, empty_ofs}, img_a);

        // parallel mode
        do_reset(1);
        chk(empty_ofs == DEF_E && full_ofs == DEF_F, "R1 default offsets parallel",
            {full_ofs, empty_ofs}, {DEF_F, DEF_E});
        w0 = 36'hFFFFFF2A5; w1 = 36'h0000001B3; w2 = 36'h5A5A5A3C1; w3 = 36'hF0F0F00AA;
        par_word(w0); par_word(w1);
        repeat (3) @(negedge clk);
        chk({full_ofs, empty_ofs} == {DEF_F, DEF_E}, "R9 no update after two words",
            {full_ofs, empty_ofs}, {DEF_F, DEF_E});
        chk(!afull_valid && !aempty_valid, "R7 parallel invalid mid-load",
            {afull_valid, aempty_valid}, 2'b00);
        load_n = 1; wr_en_n = 0; wr_data = '1;       // ordinary write
        ser_en_n = 0; ser_din = 1;                    // serial activity
        repeat (3) @(negedge clk);
        wr_en_n = 1; ser_en_n = 1;
        par_word(w2); par_word(w3);
        chk(empty_ofs == {w1[8:0], w0[9:0]}, "R8 empty from words 1 and 2",
            38'(empty_ofs), 38'({w1[8:0], w0[9:0]}));
        chk(full_ofs == {w3[8:0], w2[9:0]}, "R9 full lower/upper split",
            38'(full_ofs), 38'({w3[8:0], w2[9:0]}));
        repeat (3) @(negedge clk);
        chk(afull_valid && aempty_valid, "R6 parallel valid",
            {afull_valid, aempty_valid}, 2'b11);
        par_word(36'h000000001); par_word(36'h000000100);
        par_word(36'h0000003FF); par_word(36'h000000000);
        chk(empty_ofs == 19'h40001 && full_ofs == 19'h003FF, "R9 wrap to empty",
            {full_ofs, empty_ofs}, {19'h003FF, 19'h40001});
        load_n = 0; ser_en_n = 0; ser_din = 1;
        repeat (5) @(negedge clk);
        load_n = 1; ser_en_n = 1;
        chk(empty_ofs == 19'h40001 && full_ofs == 19'h003FF && afull_valid,
            "R10 parallel ignores serial", {full_ofs, empty_ofs},
            {19'h003FF, 19'h40001});
        repeat (2) @(negedge clk);
        summary();
    end
endmodule